// File: doc/BRIEF.md
# Page-Write Buffer and Address Counter

This block sits between a serial-bus front end that has already turned bus traffic into byte-level commands and a 16K x 8 non-volatile array. It owns the current-address counter that every read and write starts from. Incoming write bytes are not sent to the array one by one. They are gathered in a 64-slot page buffer, and the array sees them only when the front end reports a stop. The block then walks the buffer, writes every slot that was filled, and holds a busy flag for a programmable write time.

The front end sends one command per cycle on `cmd_valid`/`cmd_kind`/`cmd_byte`. The address is loaded as a high byte and then a low byte. Write bytes land in the page at the counter's low six bits, and those bits wrap inside the page. A read request returns the array byte at the counter one cycle later and steps the counter across the whole array. A write-protect input sampled at stop decides whether the gathered page reaches the array or is thrown away. While busy, every command is dropped.

Top module: `eepw_page_engine`

## Requirements
- R1: After reset `busy` and `rd_valid` are low and the current address is 0, so the first read request returns the byte stored at address 0.
- R2: Command code 1 (`cmd_kind`=3'd1) keeps bits 5..0 of `cmd_byte` as address bits 13..8 and ignores bits 7..6. Code 2 supplies address bits 7..0 and sets the current address to the combined 14-bit value.
- R3: Code 3 stores `cmd_byte` in the buffer slot named by address bits 5..0. It then adds one to bits 5..0 only, wrapping 63 to 0, and leaves bits 13..6 unchanged. A later byte to the same slot replaces the earlier one.
- R4: The array is not written while bytes are being gathered. A stop (code 5) with at least one filled slot and `wp_in` low writes each filled slot of the addressed page with its last byte and leaves the other bytes of that page unchanged.
- R5: After such a stop, `busy` is high from the next cycle for 64 + WR_CYCLES cycles, and `arr_we` is high only while `busy` is high.
- R6: Every command given while `busy` is high is dropped. It returns no read byte and changes neither the current address nor the buffer.
- R7: Read request code 4 sets `rd_valid` high for one cycle on the next cycle, with `rd_data` equal to the array byte at the current address. The address then increments over the full array, wrapping 16383 to 0.
- R8: When a write ends on the last byte of a page, the next read starts at the first byte of that same page.
- R9: If `wp_in` is high when the stop is accepted, the gathered bytes are discarded, `busy` stays low and the array is not written.
- R10: A stop with no buffered byte starts no write cycle (`busy` stays low) and leaves the loaded address in place for reads.
- R11: A new address-high command discards any bytes gathered but not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_kind | input | 3 | 1 addr high, 2 addr low, 3 write byte, 4 read request, 5 stop; others are no-ops |
| cmd_byte | input | 8 | Command payload |
| wp_in | input | 1 | Write protect, sampled at stop |
| busy | output | 1 | Commit and timed write in progress |
| rd_valid | output | 1 | Read byte present on rd_data |
| rd_data | output | 8 | Read byte |
| arr_addr | output | 14 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write enable |
| arr_rdata | input | 8 | Array read data, combinational from arr_addr |

## Verification
The bench targets four corner cases. The first is a page write longer than a page: a counter that carried into bit 6 would spill into the next page, or would keep the stale first value in a slot that was written twice. The second is a read through address 16383: a counter that wraps within the page would return byte 16320 in place of byte 0. The third is the page-end wrap after a write, where a wrong design would resume at the next page. The fourth is commands during busy, a write-protected stop and an address-only stop. A wrong design would then move the address, write the array under protection, or raise busy with nothing to commit.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ADDR_HI = 3'd1,
    CMD_ADDR_LO = 3'd2,
    CMD_WDATA   = 3'd3,
    CMD_RDATA   = 3'd4,
    CMD_STOP    = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SCAN = 2'd1,
    SQ_HOLD = 2'd2
  } seq_e;
endpackage

// File: rtl/eepw_addr_ctr.sv
module eepw_addr_ctr #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic [ADDR_W-9:0] hi_bits,
  input  logic              ld_lo,
  input  logic [7:0]        lo_bits,
  input  logic              step_page,
  input  logic              step_full,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] low_inc;

  assign low_inc = addr_q[PAGE_W-1:0] + 1'b1;

  always_comb begin
    hi_d   = hi_q;
    addr_d = addr_q;
    if (ld_hi) hi_d = hi_bits;
    if (ld_lo) begin
      addr_d = {hi_q, lo_bits};
    end else if (step_page) begin
      addr_d = {addr_q[ADDR_W-1:PAGE_W], low_inc};
    end else if (step_full) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      hi_q   <= hi_d;
      addr_q <= addr_d;
    end
  end

  assign cur_addr = addr_q;
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_filled,
  output logic              any_filled
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [DEPTH-1:0]  slot_vld;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] data_q;
    logic              vld_q;
    logic              vld_d;

    assign hit = wr_en && (wr_slot == PAGE_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (clr)      vld_d = 1'b0;
      else if (hit) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit) data_q <= wr_data;
    end

    assign slot_data[g] = data_q;
    assign slot_vld[g]  = vld_q;
  end

  assign rd_data    = slot_data[rd_slot];
  assign rd_filled  = slot_vld[rd_slot];
  assign any_filled = |slot_vld;
endmodule

// File: rtl/eepw_wr_seq.sv
module eepw_wr_seq
  import eepw_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_go,
  input  logic              wp,
  input  logic              any_filled,
  output logic              busy,
  output logic              scanning,
  output logic [PAGE_W-1:0] slot,
  output logic              buf_clr
);
  localparam int TMR_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [PAGE_W-1:0] LAST_SLOT = '1;
  localparam logic [TMR_W-1:0]  TMR_END   = TMR_W'(WR_CYCLES - 1);

  seq_e              st_q, st_d;
  logic [PAGE_W-1:0] slot_q, slot_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;

  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    tmr_d   = tmr_q;
    buf_clr = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (stop_go && any_filled) begin
          if (wp) begin
            buf_clr = 1'b1;
          end else begin
            st_d   = SQ_SCAN;
            slot_d = '0;
          end
        end
      end
      SQ_SCAN: begin
        slot_d = slot_q + 1'b1;
        if (slot_q == LAST_SLOT) begin
          st_d    = SQ_HOLD;
          tmr_d   = '0;
          buf_clr = 1'b1;
        end
      end
      SQ_HOLD: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_END) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      slot_q <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      tmr_q  <= tmr_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign scanning = (st_q == SQ_SCAN);
  assign slot     = slot_q;
endmodule

// File: rtl/eepw_page_engine.sv
module eepw_page_engine
  import eepw_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int PAGE_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [7:0]        cmd_byte,
  input  logic              wp_in,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_we,
  input  logic [DATA_W-1:0] arr_rdata
);
  localparam int HI_W = ADDR_W - 8;

  logic              take;
  logic              go_hi, go_lo, go_wd, go_rd, go_stop;
  logic [ADDR_W-1:0] cur_addr;
  logic              scanning, seq_clr, buf_clr;
  logic [PAGE_W-1:0] scan_slot;
  logic [DATA_W-1:0] buf_rdata;
  logic              buf_rfilled, buf_any;
  logic              rdv_q, rdv_d;
  logic [DATA_W-1:0] rdd_q, rdd_d;

  assign take    = cmd_valid && !busy;
  assign go_hi   = take && (cmd_kind == CMD_ADDR_HI);
  assign go_lo   = take && (cmd_kind == CMD_ADDR_LO);
  assign go_wd   = take && (cmd_kind == CMD_WDATA);
  assign go_rd   = take && (cmd_kind == CMD_RDATA);
  assign go_stop = take && (cmd_kind == CMD_STOP);

  eepw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_hi     (go_hi),
    .hi_bits   (cmd_byte[HI_W-1:0]),
    .ld_lo     (go_lo),
    .lo_bits   (cmd_byte),
    .step_page (go_wd),
    .step_full (go_rd),
    .cur_addr  (cur_addr)
  );

  assign buf_clr = seq_clr || go_hi;

  eepw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (go_wd),
    .wr_slot    (cur_addr[PAGE_W-1:0]),
    .wr_data    (cmd_byte[DATA_W-1:0]),
    .clr        (buf_clr),
    .rd_slot    (scan_slot),
    .rd_data    (buf_rdata),
    .rd_filled  (buf_rfilled),
    .any_filled (buf_any)
  );

  eepw_wr_seq #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_go    (go_stop),
    .wp         (wp_in),
    .any_filled (buf_any),
    .busy       (busy),
    .scanning   (scanning),
    .slot       (scan_slot),
    .buf_clr    (seq_clr)
  );

  assign arr_addr  = scanning ? {cur_addr[ADDR_W-1:PAGE_W], scan_slot} : cur_addr;
  assign arr_wdata = buf_rdata;
  assign arr_we    = scanning && buf_rfilled;

  always_comb begin
    rdv_d = go_rd;
    rdd_d = rdd_q;
    if (go_rd) rdd_d = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      rdv_q <= rdv_d;
      rdd_q <= rdd_d;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker
  import eepw_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic              wp_in,
  input logic              busy,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              arr_we
);
  logic acc_rd, acc_wd, acc_stop;
  assign acc_rd   = cmd_valid && !busy && (cmd_kind == CMD_RDATA);
  assign acc_wd   = cmd_valid && !busy && (cmd_kind == CMD_WDATA);
  assign acc_stop = cmd_valid && !busy && (cmd_kind == CMD_STOP);

  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_wp_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stop && wp_in) |=> !busy);

  p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);

  p_rd_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_rd));

  p_rd_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> (arr_addr == ($past(arr_addr) + 1'b1)));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wd |=> ((arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W])) &&
                (arr_addr[PAGE_W-1:0] == ($past(arr_addr[PAGE_W-1:0]) + 1'b1))));

  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_kind == CMD_RDATA) |=> !rd_valid);
endmodule

bind eepw_page_engine eepw_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .wp_in     (wp_in),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .arr_addr  (arr_addr),
  .arr_we    (arr_we)
);

// File: tb/test_eepw_page_engine.sv
module test_eepw_page_engine;
  localparam int AW = 14;
  localparam int NB = 1 << AW;
  localparam int PG = 64;
  localparam int TWC = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_kind;
  logic [7:0]  cmd_byte;
  logic        wp_in;
  logic        busy, rd_valid, arr_we;
  logic [7:0]  rd_data, arr_wdata, arr_rdata;
  logic [AW-1:0] arr_addr;

  always #2 clk = ~clk;

  eepw_page_engine #(.WR_CYCLES(TWC)) i_eepw_page_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_byte(cmd_byte), .wp_in(wp_in), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_we(arr_we), .arr_rdata(arr_rdata)
  );

  logic [7:0] arr_mem [NB];
  logic [7:0] ref_mem [NB];
  logic [7:0] ref_buf [PG];
  bit         ref_bv  [PG];
  int         ref_addr;
  int         ref_hi;
  int         we_count = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 0;

  always @(posedge clk) begin
    if (arr_we) begin
      arr_mem[arr_addr] <= arr_wdata;
      we_count <= we_count + 1;
    end
  end
  assign arr_rdata = arr_mem[arr_addr];

  function automatic logic [7:0] seed_val(int a);
    return 8'((a * 37) + ((a >> 6) * 11) + 5);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] k, logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = 3'd0;
  endtask

  task automatic clear_ref_buf();
    for (int i = 0; i < PG; i++) ref_bv[i] = 0;
  endtask

  task automatic set_addr(int a, logic [1:0] junk);
    issue(3'd1, {junk, 6'(a >> 8)});
    ref_hi = (a >> 8) & 63;
    clear_ref_buf();
    issue(3'd2, 8'(a));
    ref_addr = (ref_hi << 8) | (a & 255);
  endtask

  task automatic wbyte(logic [7:0] b);
    issue(3'd3, b);
    ref_buf[ref_addr & 63] = b;
    ref_bv[ref_addr & 63] = 1;
    ref_addr = (ref_addr & ~63) | ((ref_addr + 1) & 63);
  endtask

  task automatic rbyte(string req);
    logic [7:0] exp;
    exp = ref_mem[ref_addr];
    issue(3'd4, 8'h00);
    check(rd_valid === 1'b1, req, int'(rd_valid), 1);
    check(rd_data === exp, req, int'(rd_data), int'(exp));
    ref_addr = (ref_addr + 1) % NB;
  endtask

  task automatic stop_and_wait(string req);
    bit any;
    int c;
    int we0;
    any = 0;
    for (int i = 0; i < PG; i++) any |= ref_bv[i];
    we0 = we_count;
    issue(3'd5, 8'h00);
    if (any && !wp_in) begin
      for (int i = 0; i < PG; i++)
        if (ref_bv[i]) ref_mem[(ref_addr & ~63) | i] = ref_buf[i];
      c = 0;
      while (busy === 1'b1) begin c++; @(negedge clk); end
      check(c == PG + TWC, req, c, PG + TWC);
    end else begin
      check(busy === 1'b0, req, int'(busy), 0);
      repeat (3) @(negedge clk);
      check(we_count == we0, req, we_count, we0);
    end
    clear_ref_buf();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int we0;
    int pbase;
    void'($urandom(32'h1D5EED));
    for (int i = 0; i < NB; i++) begin
      arr_mem[i] = seed_val(i);
      ref_mem[i] = seed_val(i);
    end
    clear_ref_buf();
    ref_addr = 0; ref_hi = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_byte = 8'h00; wp_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    rbyte("R1 first read at 0");

    // R2 high bits ignored, R7 wrap across array end
    set_addr(NB - 1, 2'b11);
    rbyte("R2 addr 16383");
    rbyte("R7 wrap to 0");

    // R3/R4/R5 page write longer than a page, starting at offset 60
    pbase = 37 * PG;
    set_addr(pbase + 60, 2'b00);
    we0 = we_count;
    for (int i = 0; i < 70; i++) wbyte(8'(8'hA0 + i));
    check(we_count == we0, "R4 no write before stop", we_count, we0);
    stop_and_wait("R5 busy length");
    rbyte("R3 address after in-page wrap");
    set_addr(pbase - 2, 2'b00);
    for (int i = 0; i < PG + 4; i++) rbyte("R4 page contents");

    // R8 write ending on last byte of page
    set_addr(pbase + 62, 2'b00);
    wbyte(8'h5A); wbyte(8'hC3);
    stop_and_wait("R8 commit");
    check(ref_addr == pbase, "R8 model", ref_addr, pbase);
    rbyte("R8 resume at page start");

    // R9 write protect
    wp_in = 1'b1;
    set_addr(1000, 2'b00);
    for (int i = 0; i < 5; i++) wbyte(8'h11);
    stop_and_wait("R9 protected stop");
    wp_in = 1'b0;
    set_addr(1000, 2'b00);
    rbyte("R9 data unchanged");

    // R10 stop with address only
    set_addr(4321, 2'b01);
    stop_and_wait("R10 no cycle");
    rbyte("R10 address kept");

    // R11 new address discards gathered bytes
    set_addr(2000, 2'b00);
    wbyte(8'h77); wbyte(8'h78);
    set_addr(3000, 2'b00);
    stop_and_wait("R11 discarded");
    set_addr(2000, 2'b00);
    rbyte("R11 array untouched");

    // R6 commands while busy are dropped
    set_addr(5000, 2'b00);
    wbyte(8'h42);
    issue(3'd5, 8'h00);
    ref_mem[5000] = 8'h42;
    clear_ref_buf();
    issue(3'd1, 8'h3F);
    issue(3'd2, 8'h00);
    issue(3'd3, 8'hEE);
    issue(3'd4, 8'h00);
    check(rd_valid === 1'b0, "R6 read dropped", int'(rd_valid), 0);
    while (busy === 1'b1) @(negedge clk);
    rbyte("R6 address unchanged");
    set_addr(5000, 2'b00);
    rbyte("R6 committed byte");

    // random mix
    for (int it = 0; it < 120; it++) begin
      int op, a, n;
      op = $urandom_range(0, 2);
      a  = $urandom_range(0, NB - 1);
      if (op == 0) begin
        wp_in = ($urandom_range(0, 4) == 0);
        n = $urandom_range(1, 80);
        set_addr(a, 2'($urandom_range(0, 3)));
        for (int i = 0; i < n; i++) wbyte(8'($urandom));
        stop_and_wait(wp_in ? "R9 random" : "R5 random");
        wp_in = 1'b0;
      end else begin
        if (op == 1) set_addr(a, 2'b10);
        n = $urandom_range(1, 12);
        for (int i = 0; i < n; i++) rbyte("R7 random read");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule